// File: doc/BRIEF.md
# Conditional Byte-Code Configuration Sequencer

This block walks a stream of one-byte opcodes held in a byte-wide memory and turns it into register-file writes and single-cycle control strobes. A data opcode carries a length. Two address bytes follow it, most significant first, and then the payload bytes. The payload is written to consecutive register addresses. Three other opcodes each fire one strobe: a register-update strobe, a calibration strobe and an output-synchronisation strobe.

Condition opcodes select one of eight tags, or clear the selection. While a tag is active, a data block is written only if that tag equals the externally supplied `cond_sel_i`. Otherwise the block's bytes are still fetched and are then dropped. Two markers stop a run. A pause leaves the fetch pointer just past itself, so the next start resumes there. An end marker makes the next start begin again at address 0.

Both data-carrying interfaces use valid/ready handshakes. The memory read request (`mem_req_*`) and the register write (`reg_wr_*`) each hold valid, address and data steady until ready is seen high at a clock edge. Either side may stall for any number of cycles, and the sequencer simply waits. At most one memory request is outstanding. Its byte comes back on `mem_rsp_valid_i`/`mem_rsp_data_i` and is accepted in any cycle. The sequencer fetches no new byte while a register write is waiting for ready.

Top module: `cfg_bytecode_seq`

## Requirements
- R1: An opcode 0x00..0x7F with value N is a data instruction. It writes N+1 payload bytes to register addresses starting at {first address byte, second address byte}. The address increases by one per byte.
- R2: Opcodes 0x80, 0xA0 and 0xA1 each produce exactly one single-cycle pulse, on `upd_stb_o`, `cal_stb_o` and `sync_stb_o` respectively. They consume one byte, and at most one strobe is high in any cycle.
- R3: Opcode 0xB0 sets the active tag to none. An opcode 0xB1..0xCF sets the active tag to ((op-0xB1) mod 8)+1. A data block is written only when the tag is none or equals `cond_sel_i`. Otherwise its address and payload bytes are consumed without a write. Each start resets the tag to none.
- R4: Opcode 0xFE stops the run. The next start resumes fetching at the byte just after it.
- R5: Opcode 0xFF stops the run. The next start fetches from memory address 0.
- R6: `busy_o` rises in the cycle after an accepted start and stays high until a stop opcode is processed. `done_o` then pulses for exactly one cycle with `busy_o` low. A start seen while busy is ignored.
- R7: Any other opcode (0x81..0x9F, 0xA2..0xAF, 0xD0..0xFD) is a one-byte no-op that sets `err_o`. `err_o` stays set until the next start.
- R8: While `reg_wr_valid_o` is high and `reg_wr_ready_i` is low, valid, address and data stay unchanged in the next cycle.
- R9: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, valid and address stay unchanged in the next cycle. Only one read is outstanding.
- R10: After reset, `busy_o`, `done_o`, `err_o`, both valids and all strobes are low, and the first start fetches from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or resume a run (ignored while busy) |
| cond_sel_i | input | 4 | Condition value that data blocks under an active tag must match |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a run stops |
| err_o | output | 1 | Undefined opcode seen in the current or last run |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | MEM_AW (10) | Memory byte address |
| mem_rsp_valid_i | input | 1 | Read byte valid |
| mem_rsp_data_i | input | 8 | Read byte |
| reg_wr_valid_o | output | 1 | Register write valid |
| reg_wr_ready_i | input | 1 | Register file accepts the write |
| reg_wr_addr_o | output | REG_AW (16) | Register address |
| reg_wr_data_o | output | 8 | Register data |
| upd_stb_o | output | 1 | Register-update strobe |
| cal_stb_o | output | 1 | Calibration strobe |
| sync_stb_o | output | 1 | Output-synchronisation strobe |

## Verification
A single byte image is built from pause-terminated segments, followed by a segment that ends with the end marker. Consecutive starts each walk one segment, and the first fetched address of each run shows whether pause resumes in place and end restarts at 0. The segments mix data blocks that are written with blocks suppressed by a mismatched tag, and they include a tag value that wraps past 8. This separates the matching logic from the plain length counting. Runs with both ports always ready are compared with runs that stall requests and writes on independent patterns. The written list must come out identical, which shows that back-pressure changes timing only. A second start during a run, an undefined opcode, and a one-byte data block cover the remaining edges.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  localparam logic [7:0] OPC_UPD   = 8'h80;
  localparam logic [7:0] OPC_CAL   = 8'hA0;
  localparam logic [7:0] OPC_SYNC  = 8'hA1;
  localparam logic [7:0] OPC_TAG0  = 8'hB0;
  localparam logic [7:0] OPC_TAGHI = 8'hCF;
  localparam logic [7:0] OPC_PAUSE = 8'hFE;
  localparam logic [7:0] OPC_END   = 8'hFF;

  typedef enum logic [2:0] {
    OPK_DATA, OPK_UPD, OPK_CAL, OPK_SYNC, OPK_TAG, OPK_PAUSE, OPK_END, OPK_BAD
  } opk_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_OP, SQ_AH, SQ_AL, SQ_DATA, SQ_WR, SQ_FIN
  } sq_e;

endpackage

// File: rtl/cfgseq_decode.sv
module cfgseq_decode
  import cfgseq_pkg::*;
#(
  parameter int COND_N = 8,
  localparam int CW = $clog2(COND_N + 1)
) (
  input  logic [7:0]    op_i,
  output opk_e          kind_o,
  output logic [CW-1:0] tag_o
);

  int unsigned tag_idx;

  always_comb begin
    tag_o   = '0;
    tag_idx = 0;
    if (!op_i[7])                               kind_o = OPK_DATA;
    else if (op_i == OPC_UPD)                   kind_o = OPK_UPD;
    else if (op_i == OPC_CAL)                   kind_o = OPK_CAL;
    else if (op_i == OPC_SYNC)                  kind_o = OPK_SYNC;
    else if (op_i == OPC_PAUSE)                 kind_o = OPK_PAUSE;
    else if (op_i == OPC_END)                   kind_o = OPK_END;
    else if (op_i >= OPC_TAG0 && op_i <= OPC_TAGHI) begin
      kind_o = OPK_TAG;
      if (op_i != OPC_TAG0) begin
        tag_idx = ((32'(op_i) - 32'(OPC_TAG0) - 1) % COND_N) + 1;
        tag_o   = CW'(tag_idx);
      end
    end
    else                                        kind_o = OPK_BAD;
  end

endmodule

// File: rtl/cfgseq_cond.sv
module cfgseq_cond #(
  parameter int COND_N = 8,
  localparam int CW = $clog2(COND_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          set_i,
  input  logic [CW-1:0] val_i,
  input  logic [CW-1:0] sel_i,
  output logic          apply_o
);

  logic [CW-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_q <= '0;
    else if (clr_i)  active_q <= '0;
    else if (set_i)  active_q <= val_i;
  end

  assign apply_o = (active_q == '0) || (active_q == sel_i);

  // R3: the active tag never leaves the range none..COND_N
  assert_tag_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(active_q) <= COND_N);

endmodule

// File: rtl/cfgseq_fetch.sv
module cfgseq_fetch #(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              need_i,
  input  logic              clr_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [MEM_AW-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [7:0]        rsp_data_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o
);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_e;

  fst_e              fst_q;
  logic [MEM_AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst_q <= F_IDLE;
      ptr_q <= '0;
    end else begin
      if (clr_i) ptr_q <= '0;
      unique case (fst_q)
        F_IDLE: if (need_i) fst_q <= F_REQ;
        F_REQ: if (req_ready_i) begin
          ptr_q <= ptr_q + 1'b1;
          fst_q <= F_WAIT;
        end
        F_WAIT: if (rsp_valid_i) fst_q <= F_IDLE;
        default: fst_q <= F_IDLE;
      endcase
    end
  end

  assign req_valid_o  = (fst_q == F_REQ);
  assign req_addr_o   = ptr_q;
  assign byte_valid_o = (fst_q == F_WAIT) && rsp_valid_i;
  assign byte_o       = rsp_data_i;

  // R9: a stalled read request keeps valid and address
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

endmodule

// File: rtl/cfg_bytecode_seq.sv
module cfg_bytecode_seq
  import cfgseq_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int REG_AW = 16,
  parameter int COND_N = 8,
  localparam int CW = $clog2(COND_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CW-1:0]     cond_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [MEM_AW-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [7:0]        mem_rsp_data_i,
  output logic              reg_wr_valid_o,
  input  logic              reg_wr_ready_i,
  output logic [REG_AW-1:0] reg_wr_addr_o,
  output logic [7:0]        reg_wr_data_o,
  output logic              upd_stb_o,
  output logic              cal_stb_o,
  output logic              sync_stb_o
);

  sq_e           st_q;
  logic [6:0]    cnt_q;
  logic [15:0]   wa_q;
  logic [7:0]    wd_q;
  logic          apply_q, resume_q, err_q;
  logic          upd_q, cal_q, sync_q;

  logic          need, bv, apply, go;
  logic [7:0]    byte_in;
  opk_e          kind;
  logic [CW-1:0] tag_val;

  assign go   = (st_q == SQ_IDLE) && start_i;
  assign need = (st_q == SQ_OP) || (st_q == SQ_AH) || (st_q == SQ_AL) || (st_q == SQ_DATA);

  cfgseq_fetch #(.MEM_AW(MEM_AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .need_i(need), .clr_i(go && !resume_q),
    .req_valid_o(mem_req_valid_o), .req_ready_i(mem_req_ready_i), .req_addr_o(mem_req_addr_o),
    .rsp_valid_i(mem_rsp_valid_i), .rsp_data_i(mem_rsp_data_i),
    .byte_valid_o(bv), .byte_o(byte_in)
  );

  cfgseq_decode #(.COND_N(COND_N)) u_dec (
    .op_i(byte_in), .kind_o(kind), .tag_o(tag_val)
  );

  cfgseq_cond #(.COND_N(COND_N)) u_cond (
    .clk(clk), .rst_n(rst_n), .clr_i(go),
    .set_i((st_q == SQ_OP) && bv && (kind == OPK_TAG)),
    .val_i(tag_val), .sel_i(cond_sel_i), .apply_o(apply)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; cnt_q <= '0; wa_q <= '0; wd_q <= '0;
      apply_q <= 1'b0; resume_q <= 1'b0; err_q <= 1'b0;
      upd_q <= 1'b0; cal_q <= 1'b0; sync_q <= 1'b0;
    end else begin
      upd_q <= 1'b0; cal_q <= 1'b0; sync_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          err_q <= 1'b0;
          st_q  <= SQ_OP;
        end
        SQ_OP: if (bv) begin
          unique case (kind)
            OPK_DATA: begin
              cnt_q   <= byte_in[6:0];
              apply_q <= apply;
              st_q    <= SQ_AH;
            end
            OPK_UPD:   upd_q  <= 1'b1;
            OPK_CAL:   cal_q  <= 1'b1;
            OPK_SYNC:  sync_q <= 1'b1;
            OPK_TAG:   ;
            OPK_PAUSE: begin resume_q <= 1'b1; st_q <= SQ_FIN; end
            OPK_END:   begin resume_q <= 1'b0; st_q <= SQ_FIN; end
            default:   err_q <= 1'b1;
          endcase
        end
        SQ_AH: if (bv) begin wa_q[15:8] <= byte_in; st_q <= SQ_AL;   end
        SQ_AL: if (bv) begin wa_q[7:0]  <= byte_in; st_q <= SQ_DATA; end
        SQ_DATA: if (bv) begin
          if (apply_q) begin
            wd_q <= byte_in;
            st_q <= SQ_WR;
          end else if (cnt_q == '0) st_q <= SQ_OP;
          else                      cnt_q <= cnt_q - 1'b1;
        end
        SQ_WR: if (reg_wr_ready_i) begin
          wa_q <= wa_q + 1'b1;
          if (cnt_q == '0) st_q <= SQ_OP;
          else begin
            cnt_q <= cnt_q - 1'b1;
            st_q  <= SQ_DATA;
          end
        end
        SQ_FIN:  st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o         = (st_q != SQ_IDLE) && (st_q != SQ_FIN);
  assign done_o         = (st_q == SQ_FIN);
  assign err_o          = err_q;
  assign reg_wr_valid_o = (st_q == SQ_WR);
  assign reg_wr_addr_o  = REG_AW'(wa_q);
  assign reg_wr_data_o  = wd_q;
  assign upd_stb_o      = upd_q;
  assign cal_stb_o      = cal_q;
  assign sync_stb_o     = sync_q;

  // R8: a stalled register write holds valid, address and data
  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid_o && !reg_wr_ready_i) |=>
      (reg_wr_valid_o && $stable(reg_wr_addr_o) && $stable(reg_wr_data_o)));

  // R6: done lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: busy only rises after a start request
  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R2: strobes never overlap
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_stb_o, cal_stb_o, sync_stb_o}));

  // R1: no memory fetch while a register write is pending
  assert_no_fetch_in_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid_o |=> !($rose(mem_req_valid_o)));

endmodule

// File: tb/cfg_bytecode_seq_tb.sv
module cfg_bytecode_seq_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start_i = 1'b0;
  logic [3:0]  cond_sel_i = 4'd0;
  logic        busy_o, done_o, err_o;
  logic        mem_req_valid_o, mem_req_ready_i = 1'b0;
  logic [9:0]  mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [7:0]  mem_rsp_data_i = 8'h00;
  logic        reg_wr_valid_o, reg_wr_ready_i = 1'b0;
  logic [15:0] reg_wr_addr_o;
  logic [7:0]  reg_wr_data_o;
  logic        upd_stb_o, cal_stb_o, sync_stb_o;

  cfg_bytecode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cond_sel_i(cond_sel_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .reg_wr_valid_o(reg_wr_valid_o),
    .reg_wr_ready_i(reg_wr_ready_i), .reg_wr_addr_o(reg_wr_addr_o),
    .reg_wr_data_o(reg_wr_data_o), .upd_stb_o(upd_stb_o), .cal_stb_o(cal_stb_o),
    .sync_stb_o(sync_stb_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one vector per run: condition select, stall enable, first fetch address,
  // write count, two expected writes {addr,data}, strobe counts, error flag
  typedef struct packed {
    logic [3:0]  sel;
    logic        bp;
    logic [9:0]  fa;
    logic [1:0]  nwr;
    logic [23:0] w0;
    logic [23:0] w1;
    logic        upd;
    logic        cal;
    logic        syn;
    logic        err;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{4'd1, 1'b0, 10'd0,  2'd2, 24'h0010AA, 24'h0011BB, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd3, 1'b1, 10'd7,  2'd1, 24'h020066, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'd1, 1'b1, 10'd19, 2'd1, 24'h030777, 24'h000000, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd2, 1'b1, 10'd27, 2'd2, 24'h050011, 24'h040099, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd1, 1'b1, 10'd0,  2'd2, 24'h0010AA, 24'h0011BB, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic [7:0] mem [0:63];

  // responder / monitor state
  logic        bp = 1'b0;
  int          cyc = 0;
  logic        acc = 1'b0;
  logic [9:0]  acc_addr = '0;
  logic        fa_seen = 1'b0;
  logic [9:0]  fa_addr = '0;
  int          nwr = 0;
  logic [23:0] wrec [0:3];
  int          n_upd = 0, n_cal = 0, n_syn = 0, n_done = 0;
  int          hold_viol = 0, req_viol = 0, done_busy = 0;
  logic        pw = 1'b0, pr = 1'b0;
  logic [23:0] pw_val = '0;
  logic [9:0]  pr_addr = '0;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
    // run 1: write 2 bytes at 0x0010, update, pause
    mem[0]=8'h01; mem[1]=8'h00; mem[2]=8'h10; mem[3]=8'hAA; mem[4]=8'hBB;
    mem[5]=8'h80; mem[6]=8'hFE;
    // run 2: tag 2 block, untagged block, calibrate, pause
    mem[7]=8'hB2; mem[8]=8'h00; mem[9]=8'h01; mem[10]=8'h00; mem[11]=8'h55;
    mem[12]=8'hB0; mem[13]=8'h00; mem[14]=8'h02; mem[15]=8'h00; mem[16]=8'h66;
    mem[17]=8'hA0; mem[18]=8'hFE;
    // run 3: wrapped tag 1, undefined op, sync, pause
    mem[19]=8'hB9; mem[20]=8'h00; mem[21]=8'h03; mem[22]=8'h07; mem[23]=8'h77;
    mem[24]=8'h85; mem[25]=8'hA1; mem[26]=8'hFE;
    // run 4: untagged block, tag 2 block, end
    mem[27]=8'h00; mem[28]=8'h05; mem[29]=8'h00; mem[30]=8'h11;
    mem[31]=8'hC2; mem[32]=8'h00; mem[33]=8'h04; mem[34]=8'h00; mem[35]=8'h99;
    mem[36]=8'hFF;
  end

  // memory and register-file models, driven away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (pw && !(reg_wr_valid_o && {reg_wr_addr_o, reg_wr_data_o} == pw_val)) hold_viol++;
        if (pr && !(mem_req_valid_o && mem_req_addr_o == pr_addr)) req_viol++;
      end
      mem_rsp_valid_i = 1'b0;
      if (acc) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = mem[acc_addr[5:0]];
        acc = 1'b0;
      end
      mem_req_ready_i = bp ? ((cyc % 3) != 0) : 1'b1;
      reg_wr_ready_i  = bp ? ((cyc % 4) != 1) : 1'b1;
      if (mem_req_valid_o && mem_req_ready_i) begin
        acc = 1'b1; acc_addr = mem_req_addr_o;
        if (!fa_seen) begin fa_seen = 1'b1; fa_addr = mem_req_addr_o; end
      end
      if (reg_wr_valid_o && reg_wr_ready_i) begin
        if (nwr < 4) wrec[nwr] = {reg_wr_addr_o, reg_wr_data_o};
        nwr++;
      end
      pw = reg_wr_valid_o && !reg_wr_ready_i;
      pw_val = {reg_wr_addr_o, reg_wr_data_o};
      pr = mem_req_valid_o && !mem_req_ready_i;
      pr_addr = mem_req_addr_o;
      if (upd_stb_o) n_upd++;
      if (cal_stb_o) n_cal++;
      if (sync_stb_o) n_syn++;
      if (done_o) begin n_done++; if (busy_o) done_busy++; end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy", busy_o, 0);
    chk("R10 done", done_o, 0);
    chk("R10 err", err_o, 0);
    chk("R10 req_valid", mem_req_valid_o, 0);
    chk("R10 wr_valid", reg_wr_valid_o, 0);
    chk("R10 strobes", {upd_stb_o, cal_stb_o, sync_stb_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      int wait_cyc;
      cond_sel_i = VEC[v].sel;
      bp = VEC[v].bp;
      nwr = 0; n_upd = 0; n_cal = 0; n_syn = 0; n_done = 0; fa_seen = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk($sformatf("R6 busy after start v%0d", v), busy_o, 1);
      if (v == 1) begin
        // R6: second start during a run is ignored
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
      wait_cyc = 0;
      while (n_done == 0 && wait_cyc < 2000) begin
        @(negedge clk);
        wait_cyc++;
      end
      repeat (3) @(negedge clk);
      chk($sformatf("R6 done count v%0d", v), n_done, 1);
      chk($sformatf("R6 busy after done v%0d", v), busy_o, 0);
      chk($sformatf("R4 R5 first fetch v%0d", v), fa_addr, VEC[v].fa);
      chk($sformatf("R1 R3 write count v%0d", v), nwr, VEC[v].nwr);
      if (nwr >= 1) chk($sformatf("R1 R3 write0 v%0d", v), wrec[0], VEC[v].w0);
      if (nwr >= 2) chk($sformatf("R1 write1 v%0d", v), wrec[1], VEC[v].w1);
      chk($sformatf("R2 update v%0d", v), n_upd, VEC[v].upd);
      chk($sformatf("R2 cal v%0d", v), n_cal, VEC[v].cal);
      chk($sformatf("R2 sync v%0d", v), n_syn, VEC[v].syn);
      chk($sformatf("R7 err v%0d", v), err_o, VEC[v].err);
    end

    chk("R6 done with busy low", done_busy, 0);
    chk("R8 write hold", hold_viol, 0);
    chk("R9 request hold", req_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule